// File: doc/BRIEF.md
# Debug power and reset control register

This block is a single 32-bit control register that an external debugger reaches over a simple one-cycle register port. Through it the debugger keeps the core's power domain alive (it asks for power-up, or asks that a powerdown be emulated instead of performed), and it can ask for a warm reset of the core. Three outputs carry these requests to the power controller and the reset network, both of which lie outside the block.

The register's fields belong to two power domains, and each domain has its own reset. The power-up request lives in the debug domain and clears only on a debug reset. The no-powerdown request lives in the core domain and, on a cold reset, takes over the present value of the power-up request. Each access is allowed, refused or returned as read-only according to the core-powered status and three locks: double lock, OS lock and software lock. A write of 1 to the reset-request bit is also filtered by the debug-authentication and security configuration.

A parameter `ALL_CORE` moves every field into the core domain. In that variant the power-up field does not exist, and any access while the core is unpowered returns an error response.

Top module: `dbg_pwr_rst_ctl`

## Requirements
- R1: After a debug reset, bit 3 reads 0 and `pwrup_req_o` is 0. Warm and cold resets leave bit 3 unchanged.
- R2: With `ALL_CORE`=0 and the software lock clear, a write at the register address loads bit 3 from write-data bit 3. This works even while the core is unpowered. `pwrup_req_o` follows the stored bit. While the software lock is set, the bit keeps its value.
- R3: While the cold reset is applied, bit 0 is loaded with the current value of bit 3. Warm and debug resets leave bit 0 unchanged.
- R4: A write loads bit 0 from write-data bit 0 only when the core is powered and the double, OS and software locks are all clear. `no_pwrdn_o` follows the stored bit.
- R5: When the core is unpowered, or the double lock or OS lock is set, bit 0 reads as 0.
- R6: Bit 1 always reads 0. An accepted write with write-data bit 1 set raises `rst_req_o` for exactly one cycle, in the cycle after the write. A write with bit 1 clear raises nothing.
- R7: A write of 1 to bit 1 is ignored when the core is unpowered or any of the three locks is set.
- R8: A write of 1 to bit 1 is ignored in these cases: `mon_lvl_i`=1 and `sec_inv_dbg_en_i`=0; `mon_lvl_i`=0 with `sec_state_i`=0 and `inv_dbg_en_i`=0; `mon_lvl_i`=0 with `sec_state_i`=1 and `sec_inv_dbg_en_i`=0.
- R9: Bits 31:4 and bit 2 read as 0, and writes to them have no effect.
- R10: With `ALL_CORE`=1, bit 3 reads 0 and `pwrup_req_o` stays 0. An access while the core is unpowered raises `acc_err_o`, returns read data 0 and changes nothing.
- R11: An access to an address other than `REG_OFS` changes nothing, returns read data 0 and raises no error. Read data and the error flag belong to the cycle in which `acc_rd_i`/`acc_wr_i` is high, and read data is 0 when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| dbg_rst_ni | input | 1 | Debug-domain reset, active low |
| cold_rst_ni | input | 1 | Core cold reset, active low |
| warm_rst_ni | input | 1 | Core warm reset, active low |
| acc_rd_i | input | 1 | Read strobe |
| acc_wr_i | input | 1 | Write strobe |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, valid in the access cycle |
| acc_err_o | output | 1 | Error response for the access |
| core_pwr_i | input | 1 | Core domain is powered |
| dbl_lock_i | input | 1 | Double lock set |
| os_lock_i | input | 1 | OS lock set |
| sw_lock_i | input | 1 | Software lock set |
| mon_lvl_i | input | 1 | Highest (monitor) privilege level is present |
| sec_state_i | input | 1 | Security state when no monitor level: 1 secure, 0 non-secure |
| inv_dbg_en_i | input | 1 | Invasive debug enabled |
| sec_inv_dbg_en_i | input | 1 | Secure invasive debug enabled |
| pwrup_req_o | output | 1 | Core power-up request |
| no_pwrdn_o | output | 1 | No-powerdown (emulate powerdown) request |
| rst_req_o | output | 1 | Warm-reset request, one-cycle pulse |

## Verification
The bench builds two instances side by side with the same stimulus: one with `ALL_CORE`=0 and one with `ALL_CORE`=1. Both keep the default address width and offset. The split-domain instance reaches the debug-domain field, which can be written while the core is unpowered and survives cold and warm resets, and the cold-reset copy of that field into the no-powerdown bit. The single-domain instance reaches the error response on unpowered access and the zero cold-reset copy.

// File: rtl/dprc_pkg.sv
`timescale 1ns/1ps
package dprc_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned PU_BIT  = 3;
  localparam int unsigned RR_BIT  = 1;
  localparam int unsigned NPD_BIT = 0;
  localparam int unsigned RST_N   = 3;   // debug, cold, warm

  typedef struct packed {
    logic rd_ok;    // read accepted, drive data
    logic err;      // error response
    logic pu_we;    // load power-up field
    logic npd_we;   // load no-powerdown field
    logic npd_vis;  // no-powerdown field is readable
    logic rr_fire;  // emit reset-request pulse
  } dprc_gate_t;
endpackage

// File: rtl/dprc_rst_sync.sv
`timescale 1ns/1ps
module dprc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/dprc_gate.sv
`timescale 1ns/1ps
module dprc_gate
  import dprc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned REG_OFS  = 'h310,
  parameter bit          ALL_CORE = 1'b0
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_rr_i,
  input  logic              core_pwr_i,
  input  logic              dbl_lock_i,
  input  logic              os_lock_i,
  input  logic              sw_lock_i,
  input  logic              mon_lvl_i,
  input  logic              sec_state_i,
  input  logic              inv_dbg_en_i,
  input  logic              sec_inv_dbg_en_i,
  output dprc_gate_t        gate_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic hit, err, wr_ok, core_open, auth_ok;

  always_comb begin
    hit       = (addr_i == OFS);
    err       = ALL_CORE && hit && (rd_i || wr_i) && !core_pwr_i;
    wr_ok     = hit && wr_i && !err;
    core_open = core_pwr_i && !dbl_lock_i && !os_lock_i;
    if (mon_lvl_i)        auth_ok = sec_inv_dbg_en_i;
    else if (sec_state_i) auth_ok = sec_inv_dbg_en_i;
    else                  auth_ok = inv_dbg_en_i;

    gate_o.rd_ok   = hit && rd_i && !err;
    gate_o.err     = err;
    gate_o.pu_we   = wr_ok && !sw_lock_i && !ALL_CORE;
    gate_o.npd_we  = wr_ok && core_open && !sw_lock_i;
    gate_o.npd_vis = core_open;
    gate_o.rr_fire = wr_ok && core_open && !sw_lock_i && auth_ok && wbit_rr_i;
  end
endmodule

// File: rtl/dprc_store.sv
`timescale 1ns/1ps
module dprc_store
  import dprc_pkg::*;
#(
  parameter bit ALL_CORE = 1'b0
) (
  input  logic       clk_i,
  input  logic       dbg_rst_ni,
  input  logic       cold_rst_ni,
  input  logic       core_rst_ni,
  input  dprc_gate_t gate_i,
  input  logic       wbit_pu_i,
  input  logic       wbit_npd_i,
  output logic       pu_o,
  output logic       npd_o,
  output logic       rr_o
);
  logic pu_q;
  logic npd_q, npd_d;
  logic rr_q,  rr_d;

  // Debug-domain field; absent when every field is in the core domain.
  if (ALL_CORE) begin : g_pu_none
    assign pu_q = 1'b0;
    logic unused_pu;
    assign unused_pu = gate_i.pu_we ^ wbit_pu_i;
  end else begin : g_pu_reg
    logic pu_d, pu_r;
    always_comb pu_d = gate_i.pu_we ? wbit_pu_i : pu_r;
    always_ff @(posedge clk_i or negedge dbg_rst_ni) begin
      if (!dbg_rst_ni) pu_r <= 1'b0;
      else             pu_r <= pu_d;
    end
    assign pu_q = pu_r;
  end

  // Core-domain field: cold reset is a synchronous load from the power-up field.
  always_comb begin
    if (!cold_rst_ni)        npd_d = pu_q;
    else if (gate_i.npd_we)  npd_d = wbit_npd_i;
    else                     npd_d = npd_q;
  end

  always_ff @(posedge clk_i) begin
    npd_q <= npd_d;
  end

  always_comb rr_d = gate_i.rr_fire;

  always_ff @(posedge clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) rr_q <= 1'b0;
    else              rr_q <= rr_d;
  end

  assign pu_o  = pu_q;
  assign npd_o = npd_q;
  assign rr_o  = rr_q;
endmodule

// File: rtl/dprc_rdmux.sv
`timescale 1ns/1ps
module dprc_rdmux
  import dprc_pkg::*;
(
  input  logic             rd_ok_i,
  input  logic             npd_vis_i,
  input  logic             pu_i,
  input  logic             npd_i,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_ok_i) begin
      rdata_o[PU_BIT]  = pu_i;
      rdata_o[NPD_BIT] = npd_i && npd_vis_i;
    end
  end
endmodule

// File: rtl/dbg_pwr_rst_ctl.sv
`timescale 1ns/1ps
module dbg_pwr_rst_ctl
  import dprc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned REG_OFS  = 'h310,
  parameter bit          ALL_CORE = 1'b0
) (
  input  logic              clk_i,
  input  logic              dbg_rst_ni,
  input  logic              cold_rst_ni,
  input  logic              warm_rst_ni,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [REG_W-1:0]  acc_wdata_i,
  output logic [REG_W-1:0]  acc_rdata_o,
  output logic              acc_err_o,
  input  logic              core_pwr_i,
  input  logic              dbl_lock_i,
  input  logic              os_lock_i,
  input  logic              sw_lock_i,
  input  logic              mon_lvl_i,
  input  logic              sec_state_i,
  input  logic              inv_dbg_en_i,
  input  logic              sec_inv_dbg_en_i,
  output logic              pwrup_req_o,
  output logic              no_pwrdn_o,
  output logic              rst_req_o
);
  logic [RST_N-1:0] raw_n, sync_n;
  logic             core_rst_n;
  dprc_gate_t       gate;
  logic             pu, npd, rr;
  logic             unused_wdata;

  assign raw_n = {warm_rst_ni, cold_rst_ni, dbg_rst_ni};

  for (genvar g = 0; g < RST_N; g++) begin : g_rst
    dprc_rst_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (raw_n[g]),
      .rst_no (sync_n[g])
    );
  end

  assign core_rst_n   = sync_n[1] & sync_n[2];
  assign unused_wdata = ^{acc_wdata_i[REG_W-1:PU_BIT+1], acc_wdata_i[RR_BIT+1]};

  dprc_gate #(
    .ADDR_W   (ADDR_W),
    .REG_OFS  (REG_OFS),
    .ALL_CORE (ALL_CORE)
  ) u_gate (
    .rd_i             (acc_rd_i),
    .wr_i             (acc_wr_i),
    .addr_i           (acc_addr_i),
    .wbit_rr_i        (acc_wdata_i[RR_BIT]),
    .core_pwr_i       (core_pwr_i),
    .dbl_lock_i       (dbl_lock_i),
    .os_lock_i        (os_lock_i),
    .sw_lock_i        (sw_lock_i),
    .mon_lvl_i        (mon_lvl_i),
    .sec_state_i      (sec_state_i),
    .inv_dbg_en_i     (inv_dbg_en_i),
    .sec_inv_dbg_en_i (sec_inv_dbg_en_i),
    .gate_o           (gate)
  );

  dprc_store #(.ALL_CORE(ALL_CORE)) u_store (
    .clk_i       (clk_i),
    .dbg_rst_ni  (sync_n[0]),
    .cold_rst_ni (sync_n[1]),
    .core_rst_ni (core_rst_n),
    .gate_i      (gate),
    .wbit_pu_i   (acc_wdata_i[PU_BIT]),
    .wbit_npd_i  (acc_wdata_i[NPD_BIT]),
    .pu_o        (pu),
    .npd_o       (npd),
    .rr_o        (rr)
  );

  dprc_rdmux u_rdmux (
    .rd_ok_i   (gate.rd_ok),
    .npd_vis_i (gate.npd_vis),
    .pu_i      (pu),
    .npd_i     (npd),
    .rdata_o   (acc_rdata_o)
  );

  assign acc_err_o   = gate.err;
  assign pwrup_req_o = pu;
  assign no_pwrdn_o  = npd;
  assign rst_req_o   = rr;
endmodule

// File: rtl/dprc_chk.sv
`timescale 1ns/1ps
module dprc_chk (
  input logic        clk_i,
  input logic        dbg_rst_ni,
  input logic        cold_rst_ni,
  input logic        warm_rst_ni,
  input logic        acc_wr_i,
  input logic [31:0] acc_rdata_o,
  input logic        acc_err_o,
  input logic        core_pwr_i,
  input logic        dbl_lock_i,
  input logic        os_lock_i,
  input logic        sw_lock_i,
  input logic        mon_lvl_i,
  input logic        sec_state_i,
  input logic        inv_dbg_en_i,
  input logic        sec_inv_dbg_en_i,
  input logic        pwrup_req_o,
  input logic        no_pwrdn_o,
  input logic        rst_req_o
);
  // R2
  pu_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!dbg_rst_ni)
    $past(sw_lock_i) |-> $stable(pwrup_req_o));

  // R4
  npd_write_only_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
    !$stable(no_pwrdn_o) |-> ($past(acc_wr_i) || $past(acc_wr_i, 2)));

  // R5
  npd_hidden_chk: assert property (@(posedge clk_i) disable iff (!dbg_rst_ni)
    (!core_pwr_i || dbl_lock_i || os_lock_i) |-> !acc_rdata_o[0]);

  // R6
  rr_single_chk: assert property (@(posedge clk_i) disable iff (!warm_rst_ni || !cold_rst_ni)
    rst_req_o |=> !rst_req_o);

  // R7
  rr_open_chk: assert property (@(posedge clk_i) disable iff (!warm_rst_ni || !cold_rst_ni)
    rst_req_o |-> $past(acc_wr_i && core_pwr_i && !dbl_lock_i && !os_lock_i && !sw_lock_i));

  // R8
  rr_auth_chk: assert property (@(posedge clk_i) disable iff (!warm_rst_ni || !cold_rst_ni)
    rst_req_o |-> $past(mon_lvl_i ? sec_inv_dbg_en_i
                                  : (sec_state_i ? sec_inv_dbg_en_i : inv_dbg_en_i)));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!dbg_rst_ni)
    (acc_rdata_o[31:4] == '0) && !acc_rdata_o[2] && !acc_rdata_o[1]);

  // R10
  err_no_data_chk: assert property (@(posedge clk_i) disable iff (!dbg_rst_ni)
    acc_err_o |-> (acc_rdata_o == '0) && !core_pwr_i);
endmodule

bind dbg_pwr_rst_ctl dprc_chk u_chk (
  .clk_i            (clk_i),
  .dbg_rst_ni       (dbg_rst_ni),
  .cold_rst_ni      (cold_rst_ni),
  .warm_rst_ni      (warm_rst_ni),
  .acc_wr_i         (acc_wr_i),
  .acc_rdata_o      (acc_rdata_o),
  .acc_err_o        (acc_err_o),
  .core_pwr_i       (core_pwr_i),
  .dbl_lock_i       (dbl_lock_i),
  .os_lock_i        (os_lock_i),
  .sw_lock_i        (sw_lock_i),
  .mon_lvl_i        (mon_lvl_i),
  .sec_state_i      (sec_state_i),
  .inv_dbg_en_i     (inv_dbg_en_i),
  .sec_inv_dbg_en_i (sec_inv_dbg_en_i),
  .pwrup_req_o      (pwrup_req_o),
  .no_pwrdn_o       (no_pwrdn_o),
  .rst_req_o        (rst_req_o)
);

// File: tb/dbg_pwr_rst_ctl_tb.sv
`timescale 1ns/1ps
module dbg_pwr_rst_ctl_tb;
  localparam logic [11:0] OFS = 12'h310;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        dbg_rst_n, cold_rst_n, warm_rst_n;
  logic        rd, wr;
  logic [11:0] addr;
  logic [31:0] wd;
  logic        pwr, dl, osl, swl, mon, sst, inv, sinv;

  logic [31:0] rdata [2];
  logic        err   [2];
  logic        pu    [2];
  logic        npd   [2];
  logic        rr    [2];

  dbg_pwr_rst_ctl #(.ALL_CORE(1'b0)) u_dut (
    .clk_i(clk), .dbg_rst_ni(dbg_rst_n), .cold_rst_ni(cold_rst_n), .warm_rst_ni(warm_rst_n),
    .acc_rd_i(rd), .acc_wr_i(wr), .acc_addr_i(addr), .acc_wdata_i(wd),
    .acc_rdata_o(rdata[0]), .acc_err_o(err[0]),
    .core_pwr_i(pwr), .dbl_lock_i(dl), .os_lock_i(osl), .sw_lock_i(swl),
    .mon_lvl_i(mon), .sec_state_i(sst), .inv_dbg_en_i(inv), .sec_inv_dbg_en_i(sinv),
    .pwrup_req_o(pu[0]), .no_pwrdn_o(npd[0]), .rst_req_o(rr[0]));

  dbg_pwr_rst_ctl #(.ALL_CORE(1'b1)) u_dut_ac (
    .clk_i(clk), .dbg_rst_ni(dbg_rst_n), .cold_rst_ni(cold_rst_n), .warm_rst_ni(warm_rst_n),
    .acc_rd_i(rd), .acc_wr_i(wr), .acc_addr_i(addr), .acc_wdata_i(wd),
    .acc_rdata_o(rdata[1]), .acc_err_o(err[1]),
    .core_pwr_i(pwr), .dbl_lock_i(dl), .os_lock_i(osl), .sw_lock_i(swl),
    .mon_lvl_i(mon), .sec_state_i(sst), .inv_dbg_en_i(inv), .sec_inv_dbg_en_i(sinv),
    .pwrup_req_o(pu[1]), .no_pwrdn_o(npd[1]), .rst_req_o(rr[1]));

  // Behavioural reference state
  bit m_pu [2];
  bit m_npd[2];
  bit m_rr [2];
  bit s1[3];
  bit s2[3];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic bit auth_ok();
    if (mon) return sinv;
    return sst ? sinv : inv;
  endfunction

  always @(posedge clk) begin
    bit raw[3];
    bit rs[3];
    raw = '{dbg_rst_n, cold_rst_n, warm_rst_n};
    for (int i = 0; i < 3; i++) rs[i] = raw[i] && s2[i];
    for (int k = 0; k < 2; k++) begin
      bit ac, hit, er, wok, open, pu_old;
      ac     = (k == 1);
      hit    = (addr == OFS);
      er     = ac && hit && (rd || wr) && !pwr;
      wok    = hit && wr && !er;
      open   = pwr && !dl && !osl && !swl;
      pu_old = m_pu[k];
      if (!rs[0])                 m_pu[k] = 0;
      else if (wok && !ac && !swl) m_pu[k] = wd[3];
      if (!rs[1])                 m_npd[k] = pu_old;
      else if (wok && open)       m_npd[k] = wd[0];
      if (!rs[1] || !rs[2])       m_rr[k] = 0;
      else                        m_rr[k] = wok && open && auth_ok() && wd[1];
    end
    for (int i = 0; i < 3; i++) begin
      s2[i] = raw[i] ? s1[i] : 1'b0;
      s1[i] = raw[i];
    end
  end

  task automatic cmp(string tag, int k, string nm, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s: actual %h expected %h", tag, k, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 2; k++) begin
      bit ac, hit, er, rok, e_pu, e_rr;
      logic [31:0] e_rd;
      ac   = (k == 1);
      hit  = (addr == OFS);
      er   = ac && hit && (rd || wr) && !pwr;
      rok  = hit && rd && !er;
      e_pu = (!ac && dbg_rst_n) ? m_pu[k] : 1'b0;
      e_rr = (warm_rst_n && cold_rst_n) ? m_rr[k] : 1'b0;
      e_rd = '0;
      if (rok) begin
        e_rd[3] = e_pu;
        e_rd[0] = (pwr && !dl && !osl) ? m_npd[k] : 1'b0;
      end
      cmp(tag, k, "rdata",     rdata[k], e_rd);
      cmp(tag, k, "err",       32'(err[k]), 32'(er));
      cmp(tag, k, "pwrup_req", 32'(pu[k]),  32'(e_pu));
      cmp(tag, k, "no_pwrdn",  32'(npd[k]), 32'(m_npd[k]));
      cmp(tag, k, "rst_req",   32'(rr[k]),  32'(e_rr));
    end
  endtask

  task automatic step(string tag);
    #1;
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic acc(bit r, bit w, logic [31:0] d, string tag, logic [11:0] a = OFS);
    rd = r; wr = w; wd = d; addr = a;
    step(tag);
    rd = 0; wr = 0; wd = '0; addr = OFS;
  endtask

  task automatic wrd(logic [31:0] d, string tag);
    acc(0, 1, d, tag);
    acc(1, 0, '0, tag);
  endtask

  task automatic settle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic defaults();
    pwr = 1; dl = 0; osl = 0; swl = 0; mon = 1; sst = 0; inv = 1; sinv = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before all requirements were exercised");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    dbg_rst_n = 0; cold_rst_n = 0; warm_rst_n = 0;
    rd = 0; wr = 0; addr = OFS; wd = '0;
    defaults();
    repeat (6) @(negedge clk);
    dbg_rst_n = 1; cold_rst_n = 1; warm_rst_n = 1;
    settle("R1", 3);
    acc(1, 0, '0, "R1");

    // R2: debug-domain bit, writable while unpowered, held by software lock
    wrd(32'h8, "R2");
    swl = 1; wrd(32'h0, "R2"); swl = 0;
    pwr = 0; wrd(32'h0, "R2");
    wrd(32'h8, "R2");                 // R10: ALL_CORE instance errors here
    acc(1, 0, '0, "R10");
    pwr = 1;

    // R1/R3: warm and cold resets keep bit 3; cold copies bit 3 into bit 0
    warm_rst_n = 0; settle("R1", 2); warm_rst_n = 1; settle("R1", 3);
    acc(1, 0, '0, "R1");
    cold_rst_n = 0; settle("R3", 2); cold_rst_n = 1; settle("R3", 3);
    acc(1, 0, '0, "R3");
    dbg_rst_n = 0; settle("R3", 2); dbg_rst_n = 1; settle("R3", 3);
    acc(1, 0, '0, "R3");
    warm_rst_n = 0; settle("R3", 2); warm_rst_n = 1; settle("R3", 3);

    // R4: bit 0 write gating
    wrd(32'h0, "R4");
    wrd(32'h1, "R4");
    dl  = 1; wrd(32'h0, "R4"); dl  = 0;
    osl = 1; wrd(32'h0, "R4"); osl = 0;
    swl = 1; wrd(32'h0, "R4"); swl = 0;
    pwr = 0; wrd(32'h0, "R4"); pwr = 1;
    acc(1, 0, '0, "R4");

    // R5: bit 0 hidden on reads
    dl  = 1; acc(1, 0, '0, "R5"); dl  = 0;
    osl = 1; acc(1, 0, '0, "R5"); osl = 0;
    pwr = 0; acc(1, 0, '0, "R5"); pwr = 1;
    swl = 1; acc(1, 0, '0, "R5"); swl = 0;

    // R6: reset-request pulse
    acc(0, 1, 32'h2, "R6");
    settle("R6", 2);
    acc(0, 1, 32'h0, "R6");
    settle("R6", 1);
    acc(0, 1, 32'h3, "R6");
    acc(1, 0, '0, "R6");

    // R7: pulse blocked by power and locks
    pwr = 0; acc(0, 1, 32'h2, "R7"); settle("R7", 1); pwr = 1;
    dl  = 1; acc(0, 1, 32'h2, "R7"); settle("R7", 1); dl  = 0;
    osl = 1; acc(0, 1, 32'h2, "R7"); settle("R7", 1); osl = 0;
    swl = 1; acc(0, 1, 32'h2, "R7"); settle("R7", 1); swl = 0;

    // R8: authentication filter
    mon = 1; sinv = 0; inv = 1; acc(0, 1, 32'h2, "R8"); settle("R8", 1);
    mon = 0; sst = 0; inv = 0; sinv = 1; acc(0, 1, 32'h2, "R8"); settle("R8", 1);
    inv = 1; acc(0, 1, 32'h2, "R8"); settle("R8", 1);
    sst = 1; sinv = 0; acc(0, 1, 32'h2, "R8"); settle("R8", 1);
    sinv = 1; acc(0, 1, 32'h2, "R8"); settle("R8", 1);
    defaults();

    // R9: reserved bits
    wrd(32'hFFFF_FFF4, "R9");
    wrd(32'hFFFF_FFFD, "R9");
    settle("R9", 1);

    // R11: other address and idle read data
    acc(0, 1, 32'h0, "R11", 12'h314);
    acc(1, 0, '0,    "R11", 12'h314);
    acc(1, 0, '0, "R11");
    settle("R11", 2);

    // R10: single-domain instance error on read and write while unpowered
    pwr = 0;
    acc(1, 0, '0, "R10");
    acc(0, 1, 32'h0, "R10");
    pwr = 1;
    acc(1, 0, '0, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule